// File: doc/BRIEF.md
# Wide Register Access Collector

This block sits behind a 32-bit memory-mapped slave port and owns a bank of 128-bit control registers, a small 64-bit buffer-table memory and a handful of 32-bit doorbell registers. Software can only move one dword per access, but every wide register must change as a whole. The block therefore holds the leading dwords of a wide write in a collection buffer and updates the target in one step when the final dword arrives. For reads, fetching the lowest dword captures the entire current value into a read shadow, and the remaining dwords are served from that capture, so a multi-access read always returns one coherent value.

Doorbells (an event-queue read pointer, an RX descriptor pointer and a TX descriptor pointer in each page) take a lone dword write that lands at once and leaves any pending collection alone. The address space is cut into pages of 0x2000 bytes. In every page the wide registers form a table with a 16-byte stride at offset 0x000 and the doorbells sit at 0x400, 0x410 and 0x420. The buffer table exists only in page 0, at offset 0x1000, with an 8-byte stride. Two sticky flags report a final dword that closes a register other than the one being collected, and a page-0 doorbell write that interrupts a collection.

Top module: `wide_reg_collector`

## Requirements
- R1: After a synchronous active-high reset every wide register, buffer-table entry, doorbell, the collection buffer, the read shadow, `busy`, `seq_err` and `page0_hazard` read as zero.
- R2: A write to dword 0, 1 or 2 (address bits [3:2]) of a wide register goes to the collection buffer and sets `busy`; the live register keeps its old value, as a following dword-0 read shows.
- R3: A write to dword 3 loads all 128 bits (dword 3 from the write, dwords 0 to 2 from the buffer) into the addressed register in one step and clears `busy`.
- R4: A read of dword 0 returns the live dword 0 and captures the whole register into the read shadow; reads of dwords 1 to 3 return the shadow, even if the register has been rewritten since.
- R5: Buffer-table entry i lives at page-0 offset 0x1000 + 8·i; a low-dword write (address bit 2 clear) is collected, a high-dword write commits 64 bits; a low-dword read captures the entry and a high-dword read returns the capture.
- R6: A doorbell write (page offset 0x400 + 16·k, k = 0 event queue, 1 RX, 2 TX, dword 0 only) appears on `db_value[(page·3+k)·32 +: 32]` one cycle later and leaves `busy` and the collected dwords unchanged; doorbells read back their live value.
- R7: The effective address is page·0x2000 + offset; each page below PAGES holds its own register table and doorbells.
- R8: Wide register n of a page sits at offset 16·n.
- R9: A page-0 doorbell write while `busy` is high sets the sticky `page0_hazard`; the doorbell is still applied and the collection still completes.
- R10: If dword 3 (or a buffer-table high dword) targets a register other than the one that last received a collected dword while `busy` is high, the commit uses the buffer contents as they stand and the sticky `seq_err` is set.
- R11: `req_ready` is high; a read returns `rsp_valid` with data exactly one cycle after acceptance; unmapped addresses read as zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| db_value | output | PAGES·96 | All doorbell values, three per page |
| busy | output | 1 | Collection pending |
| seq_err | output | 1 | Sticky mismatched-commit flag |
| page0_hazard | output | 1 | Sticky page-0 doorbell during collection |

## Verification
The two functions that overlap are a pending wide collection and a doorbell write, and also a held read shadow and a commit to the same register. The bench interleaves a doorbell write between the leading dwords and the final dword, in page 1 and in page 0, and judges the doorbell output on the next cycle, the `busy` and hazard flags, and the four dwords read back after the commit. It also captures a register, rewrites it completely, and expects the upper dwords of the old capture before a fresh dword-0 read exposes the new value.

// File: rtl/wide_reg_collector.sv
module wide_reg_collector #(
  parameter int ADDR_W      = 16,
  parameter int PAGES       = 2,
  parameter int WIDE_REGS   = 4,
  parameter int TBL_ENTRIES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_data,
  output logic [PAGES*96-1:0]   db_value,
  output logic                  busy,
  output logic                  seq_err,
  output logic                  page0_hazard
);
  localparam int PG_W   = ADDR_W - 13;
  localparam int N_WIDE = PAGES * WIDE_REGS;
  localparam int N_DB   = PAGES * 3;
  localparam int WI_W   = (N_WIDE > 1) ? $clog2(N_WIDE) : 1;
  localparam int TI_W   = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1;
  localparam int DI_W   = (N_DB > 1) ? $clog2(N_DB) : 1;
  localparam int ID_W   = ((WI_W > TI_W) ? WI_W : TI_W) + 1;
  localparam logic [12:0] DB_BASE  = 13'h400;
  localparam logic [12:0] TBL_BASE = 13'h1000;

  logic [127:0] wreg [N_WIDE];
  logic [63:0]  tbl  [TBL_ENTRIES];
  logic [31:0]  db   [N_DB];
  logic [95:0]  cbuf;
  logic [127:0] shadow;
  logic [ID_W-1:0] tgt;

  logic [PG_W-1:0] pg;
  logic [12:0]     off, db_off, tb_off;
  logic [1:0]      dw;
  logic            pg_ok, wide_hit, db_hit, tbl_hit, tbl_hi;
  logic [WI_W-1:0] wide_idx;
  logic [TI_W-1:0] tbl_idx;
  logic [DI_W-1:0] db_idx;
  logic [ID_W-1:0] wide_id, tbl_id;
  logic            acc_wr, acc_rd;

  assign req_ready = 1'b1;
  assign acc_wr    = req_valid && req_write;
  assign acc_rd    = req_valid && !req_write;

  assign pg     = req_addr[ADDR_W-1:13];
  assign off    = req_addr[12:0];
  assign dw     = off[3:2];
  assign db_off = off - DB_BASE;
  assign tb_off = off - TBL_BASE;
  assign pg_ok  = 32'(pg) < PAGES;

  assign wide_hit = pg_ok && (32'(off) < WIDE_REGS * 16);
  assign db_hit   = pg_ok && (off >= DB_BASE) && (off < DB_BASE + 13'd48) && (dw == 2'd0);
  assign tbl_hit  = (pg == '0) && (off >= TBL_BASE) && (32'(tb_off) < TBL_ENTRIES * 8);
  assign tbl_hi   = off[2];

  assign wide_idx = WI_W'(pg) * WI_W'(WIDE_REGS) + WI_W'(off[12:4]);
  assign tbl_idx  = TI_W'(tb_off[12:3]);
  assign db_idx   = DI_W'(pg) * DI_W'(3) + DI_W'(db_off[5:4]);
  assign wide_id  = {1'b0, (ID_W-1)'(wide_idx)};
  assign tbl_id   = {1'b1, (ID_W-1)'(tbl_idx)};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_WIDE; i++) wreg[i] <= '0;
      for (int i = 0; i < TBL_ENTRIES; i++) tbl[i] <= '0;
      for (int i = 0; i < N_DB; i++) db[i] <= '0;
      cbuf         <= '0;
      shadow       <= '0;
      tgt          <= '0;
      busy         <= 1'b0;
      seq_err      <= 1'b0;
      page0_hazard <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_wr) begin
        if (wide_hit) begin
          if (dw != 2'd3) begin
            cbuf[{dw, 5'b0} +: 32] <= req_wdata;
            tgt  <= wide_id;
            busy <= 1'b1;
          end else begin
            wreg[wide_idx] <= {req_wdata, cbuf};
            busy <= 1'b0;
            if (busy && tgt != wide_id) seq_err <= 1'b1;
          end
        end else if (tbl_hit) begin
          if (!tbl_hi) begin
            cbuf[31:0] <= req_wdata;
            tgt  <= tbl_id;
            busy <= 1'b1;
          end else begin
            tbl[tbl_idx] <= {req_wdata, cbuf[31:0]};
            busy <= 1'b0;
            if (busy && tgt != tbl_id) seq_err <= 1'b1;
          end
        end else if (db_hit) begin
          db[db_idx] <= req_wdata;
          if (pg == '0 && busy) page0_hazard <= 1'b1;
        end
      end
      if (acc_rd) begin
        if (wide_hit) begin
          if (dw == 2'd0) begin
            shadow   <= wreg[wide_idx];
            rsp_data <= wreg[wide_idx][31:0];
          end else begin
            rsp_data <= shadow[{dw, 5'b0} +: 32];
          end
        end else if (tbl_hit) begin
          if (!tbl_hi) begin
            shadow[63:0] <= tbl[tbl_idx];
            rsp_data     <= tbl[tbl_idx][31:0];
          end else begin
            rsp_data <= shadow[63:32];
          end
        end else if (db_hit) begin
          rsp_data <= db[db_idx];
        end else begin
          rsp_data <= '0;
        end
      end
    end
  end

  for (genvar d = 0; d < N_DB; d++) begin : g_db
    assign db_value[d*32 +: 32] = db[d];
  end
endmodule

module wide_reg_collector_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGES  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                rsp_valid,
  input logic [PAGES*96-1:0] db_value,
  input logic                busy,
  input logic                seq_err,
  input logic                page0_hazard
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !seq_err && !page0_hazard && !rsp_valid && db_value == '0));
  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
  a_r6_db_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(db_value));
  a_r2_busy_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid && req_write));
  a_r9_hazard_sticky: assert property (@(posedge clk) disable iff (rst)
    page0_hazard |=> page0_hazard);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);
endmodule

bind wide_reg_collector wide_reg_collector_chk #(.ADDR_W(ADDR_W), .PAGES(PAGES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .db_value(db_value),
  .busy(busy), .seq_err(seq_err), .page0_hazard(page0_hazard)
);

// File: tb/test_wide_reg_collector.sv
`timescale 1ns/1ps
module test_wide_reg_collector;
  localparam int ADDR_W = 16;
  localparam int PAGES  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy, seq_err, page0_hazard;
  logic [31:0] rsp_data;
  logic [PAGES*96-1:0] db_value;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wide_reg_collector #(.ADDR_W(ADDR_W), .PAGES(PAGES)) i_wide_reg_collector (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .db_value(db_value),
    .busy(busy), .seq_err(seq_err), .page0_hazard(page0_hazard));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    chk({31'b0, rsp_valid}, 32'd1, "R11 one-cycle read latency");
  endtask

  always @(negedge clk) begin
    if (rsp_valid && !rst) begin
      if (exp_q.size() == 0) chk(32'd1, 32'd0, "R11 unexpected response");
      else chk(rsp_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  function automatic logic [31:0] dbv(input int p, input int k);
    return db_value[(p*3+k)*32 +: 32];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: got timeout expected completion");
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({29'b0, busy, seq_err, page0_hazard}, 32'd0, "R1 flags after reset");
    chk(db_value[31:0], 32'd0, "R1 doorbell after reset");
    rd(16'h0010, 32'd0, "R1 register zero");
    rd(16'h0014, 32'd0, "R1 shadow zero");
    rd(16'h1000, 32'd0, "R1 table zero");

    // R2/R3/R8: collect then commit wide register 1 of page 0
    wr(16'h0010, 32'hA000_0000);
    wr(16'h0014, 32'hA000_0001);
    wr(16'h0018, 32'hA000_0002);
    chk({31'b0, busy}, 32'd1, "R2 busy while collecting");
    rd(16'h0010, 32'd0, "R2 live unchanged dword0");
    rd(16'h0018, 32'd0, "R2 live unchanged dword2");
    wr(16'h001C, 32'hA000_0003);
    chk({31'b0, busy}, 32'd0, "R3 busy clear after commit");
    rd(16'h0010, 32'hA000_0000, "R3 dword0");
    rd(16'h0014, 32'hA000_0001, "R3 dword1");
    rd(16'h0018, 32'hA000_0002, "R3 dword2");
    rd(16'h001C, 32'hA000_0003, "R8 dword3 at stride 16");

    // R4: shadow holds old capture across a rewrite
    rd(16'h0010, 32'hA000_0000, "R4 capture");
    wr(16'h0010, 32'hB000_0000);
    wr(16'h0014, 32'hB000_0001);
    wr(16'h0018, 32'hB000_0002);
    wr(16'h001C, 32'hB000_0003);
    rd(16'h0014, 32'hA000_0001, "R4 shadow dword1 old");
    rd(16'h001C, 32'hA000_0003, "R4 shadow dword3 old");
    rd(16'h0010, 32'hB000_0000, "R4 fresh capture");
    rd(16'h0014, 32'hB000_0001, "R4 new dword1");

    // R6/R7: page-1 doorbell during a page-1 collection
    wr(16'h2020, 32'hC000_0000);
    wr(16'h2024, 32'hC000_0001);
    wr(16'h2028, 32'hC000_0002);
    wr(16'h2410, 32'hD000_0011);
    chk(dbv(1, 1), 32'hD000_0011, "R6 doorbell page1 RX immediate");
    chk({31'b0, busy}, 32'd1, "R6 collection still pending");
    chk({31'b0, page0_hazard}, 32'd0, "R9 no hazard for page1 doorbell");
    wr(16'h202C, 32'hC000_0003);
    chk({31'b0, seq_err}, 32'd0, "R10 no error on matched commit");
    rd(16'h2020, 32'hC000_0000, "R7 page1 dword0");
    rd(16'h2024, 32'hC000_0001, "R6 page1 dword1 intact");
    rd(16'h2028, 32'hC000_0002, "R6 page1 dword2 intact");
    rd(16'h202C, 32'hC000_0003, "R7 page1 dword3");
    rd(16'h0020, 32'd0, "R7 page0 reg2 independent");
    rd(16'h2410, 32'hD000_0011, "R6 doorbell readback");

    // R9: page-0 doorbell during a collection
    wr(16'h0000, 32'hE000_0000);
    wr(16'h0400, 32'hD000_0000);
    chk(dbv(0, 0), 32'hD000_0000, "R9 page0 doorbell applied");
    chk({31'b0, page0_hazard}, 32'd1, "R9 hazard set");
    wr(16'h0004, 32'hE000_0001);
    wr(16'h0008, 32'hE000_0002);
    wr(16'h000C, 32'hE000_0003);
    rd(16'h0000, 32'hE000_0000, "R9 collection completes dword0");
    rd(16'h000C, 32'hE000_0003, "R9 collection completes dword3");
    chk({31'b0, page0_hazard}, 32'd1, "R9 hazard sticky");

    // R5: buffer-table entry 1
    wr(16'h1008, 32'h5000_0000);
    chk({31'b0, busy}, 32'd1, "R5 low dword collected");
    rd(16'h1008, 32'd0, "R5 entry unchanged");
    rd(16'h100C, 32'd0, "R5 capture high unchanged");
    wr(16'h100C, 32'h5000_0001);
    rd(16'h1008, 32'h5000_0000, "R5 commit low");
    rd(16'h100C, 32'h5000_0001, "R5 commit high");

    // R10: mismatched commit
    wr(16'h0030, 32'hF000_0000);
    wr(16'h0034, 32'hF000_0001);
    wr(16'h0038, 32'hF000_0002);
    wr(16'h000C, 32'hF000_0003);
    chk({31'b0, seq_err}, 32'd1, "R10 error set");
    chk({31'b0, busy}, 32'd0, "R10 busy cleared");
    rd(16'h0000, 32'hF000_0000, "R10 buffer dword0 into target");
    rd(16'h0008, 32'hF000_0002, "R10 buffer dword2 into target");
    rd(16'h0030, 32'd0, "R10 collected register untouched");

    // R11: unmapped space
    wr(16'h0040, 32'h1234_5678);
    chk({31'b0, busy}, 32'd0, "R11 unmapped write no collection");
    rd(16'h0040, 32'd0, "R11 beyond table reads zero");
    rd(16'h0800, 32'd0, "R11 hole reads zero");
    rd(16'h4000, 32'd0, "R11 page beyond range reads zero");
    rd(16'h3008, 32'd0, "R11 table absent on page1");
    rd(16'h0404, 32'd0, "R11 doorbell upper dword unmapped");
    rd(16'h0000, 32'hF000_0000, "R11 register unchanged by unmapped write");
    chk({31'b0, seq_err}, 32'd1, "R10 error sticky");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 32'd0, "R11 all responses returned");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule